// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches one bank of up to 32 already-synchronized GPIO inputs and raises a single bank interrupt when any pin it is allowed to report has seen its trigger condition. Each pin has its own trigger settings, held in three read/write configuration registers. The first chooses edge or level detection. The second chooses the active direction or level. The third turns an edge pin into a both-edge pin. Detected events land in a sticky status register, and software clears that register by writing ones to it.

Propagation to the interrupt output is gated by a mask register. Software cannot write the mask directly. It changes the mask only through two strobe addresses: one clears mask bits and one sets them. Detection does not stop while a pin is masked. An event that arrives during masking stays pending and reaches the output as soon as the pin is unmasked.

Register access is a simple single-cycle port. A write takes effect at the clock edge on which `reg_wr` is high. Read data is a combinational function of `reg_addr` and the current register contents.

Top module: `pinbank_irq_detect`

## Requirements
- R1: When reset is released, the trigger-type, polarity and both-edge registers read as all zeros, the mask reads as all ones, status reads as all zeros, and `irq` is low.
- R2: Address 0 (trigger type: 1 = edge, 0 = level), address 1 (polarity: 1 = rising/high, 0 = falling/low) and address 2 (both-edge) are read/write and read back what was last written. The strobe addresses 3 and 4 always read as zero.
- R3: For an edge pin whose both-edge bit is 0, polarity 1 sets the pin's status bit on a 0-to-1 change of the input, and polarity 0 sets it on a 1-to-0 change. The bit becomes visible after the first rising clock edge that sees the new input value.
- R4: For an edge pin whose both-edge bit is 1, either transition sets the status bit, whatever the polarity bit holds.
- R5: For a level pin, the status bit is set on every cycle in which the input equals the polarity bit. The both-edge bit has no effect on a level pin.
- R6: Writing ones to address 3 clears the matching mask bits. Writing ones to address 4 sets them. Zero bits in either write leave the mask unchanged. The mask reads at address 5, where 1 = masked.
- R7: Status reads at address 6. Writing a 1 to a bit clears it, and a 0 leaves it alone. If a new event and a clear hit the same bit in the same cycle, the bit stays set.
- R8: Status bits are set by events while the pin is masked. A pending bit drives `irq` high in the cycle after the unmask write.
- R9: `irq` is high exactly when some status bit is set whose mask bit is clear.
- R10: Clearing the status bit of a level pin whose input is still at its active level leaves the bit set. Once the input leaves the active level, a clear takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| pin_in | input | NPINS | Synchronized pin levels |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address (0 type, 1 polarity, 2 both-edge, 3 unmask, 4 mask-set, 5 mask, 6 status) |
| reg_wdata | input | NPINS | Write data, one bit per pin |
| reg_rdata | output | NPINS | Read data for `reg_addr` |
| irq | output | 1 | Bank interrupt |

## Verification
A wrong previous-value register or a wrong event decode shows up as a status bit that is missing, or set when it should not be, on the read one cycle after the pin changes. The bench reads status after every single transition of every pin in every trigger mode, so such a fault cannot pass unseen. A corrupted mask appears as `irq` asserting while the pin should still be masked, or staying low one cycle after an unmask. A clear that wrongly wins over a new event is exposed by a dedicated cycle in which both land on the same bit.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned ADR_W = 3;

  typedef enum logic [ADR_W-1:0] {
    ADR_TRIG    = 3'd0,
    ADR_POL     = 3'd1,
    ADR_BOTH    = 3'd2,
    ADR_UNMASK  = 3'd3,
    ADR_MASKSET = 3'd4,
    ADR_MASK    = 3'd5,
    ADR_STATUS  = 3'd6
  } adr_e;
endpackage

// File: rtl/irqd_cfg_regs.sv
module irqd_cfg_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_trig,
  input  logic         wr_pol,
  input  logic         wr_both,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] trig_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] both_q
);
  logic [W-1:0] trig_d, pol_d, both_d;

  always_comb begin
    trig_d = trig_q;
    pol_d  = pol_q;
    both_d = both_q;
    if (wr_trig) trig_d = wdata;
    if (wr_pol)  pol_d  = wdata;
    if (wr_both) both_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      pol_q  <= '0;
      both_q <= '0;
    end else begin
      trig_q <= trig_d;
      pol_q  <= pol_d;
      both_q <= both_d;
    end
  end
endmodule

// File: rtl/irqd_event_detect.sv
module irqd_event_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] trig,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] both,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q, prev_d;
  logic         valid_q, valid_d;

  // Previous-cycle copy of the inputs; valid_q holds off edges until it is loaded.
  always_comb begin
    prev_d  = pin;
    valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      valid_q <= valid_d;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = pin[i] & ~prev_q[i];
    assign fall     = ~pin[i] & prev_q[i];
    assign edge_hit = both[i] ? (rise | fall) : (pol[i] ? rise : fall);
    assign lvl_hit  = pol[i] ? pin[i] : ~pin[i];
    assign evt[i]   = valid_q & (trig[i] ? edge_hit : lvl_hit);
  end
endmodule

// File: rtl/irqd_status_mask.sv
module irqd_status_mask #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         unmask_stb,
  input  logic         maskset_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] sts_q,
  output logic         irq
);
  logic [W-1:0] mask_d, sts_d, clr_bits;

  always_comb begin
    mask_d = mask_q;
    if (unmask_stb)  mask_d = mask_d & ~wdata;
    if (maskset_stb) mask_d = mask_d | wdata;
    clr_bits = clr_stb ? wdata : '0;
    sts_d    = (sts_q & ~clr_bits) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      sts_q  <= '0;
    end else begin
      mask_q <= mask_d;
      sts_q  <= sts_d;
    end
  end

  assign irq = |(sts_q & ~mask_q);

  // R7: a detected event survives a same-cycle clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((sts_q & $past(evt)) == $past(evt)));

  // R7: a status bit only rises after an event on that pin
  a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q) & ~$past(evt)) == '0));

  // R6: unmask strobe clears the selected mask bits
  a_r6_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_stb |=> ((mask_q & $past(wdata)) == '0));

  // R6: mask-set strobe sets the selected mask bits
  a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    maskset_stb |=> ((mask_q & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/pinbank_irq_detect.sv
module pinbank_irq_detect
  import irqd_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             reg_wr,
  input  logic [ADR_W-1:0] reg_addr,
  input  logic [NPINS-1:0] reg_wdata,
  output logic [NPINS-1:0] reg_rdata,
  output logic             irq
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  logic wr_trig, wr_pol, wr_both, wr_unmask, wr_maskset, wr_clr;
  always_comb begin
    wr_trig    = reg_wr && (reg_addr == ADR_TRIG);
    wr_pol     = reg_wr && (reg_addr == ADR_POL);
    wr_both    = reg_wr && (reg_addr == ADR_BOTH);
    wr_unmask  = reg_wr && (reg_addr == ADR_UNMASK);
    wr_maskset = reg_wr && (reg_addr == ADR_MASKSET);
    wr_clr     = reg_wr && (reg_addr == ADR_STATUS);
  end

  logic [NPINS-1:0] trig_q, pol_q, both_q, evt, mask_q, sts_q;

  irqd_cfg_regs #(.W(NPINS)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_trig(wr_trig), .wr_pol(wr_pol), .wr_both(wr_both),
    .wdata(reg_wdata),
    .trig_q(trig_q), .pol_q(pol_q), .both_q(both_q)
  );

  irqd_event_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst_n(rst_sync_n), .pin(pin_in),
    .trig(trig_q), .pol(pol_q), .both(both_q), .evt(evt)
  );

  irqd_status_mask #(.W(NPINS)) u_sts (
    .clk(clk), .rst_n(rst_sync_n), .evt(evt),
    .unmask_stb(wr_unmask), .maskset_stb(wr_maskset), .clr_stb(wr_clr),
    .wdata(reg_wdata), .mask_q(mask_q), .sts_q(sts_q), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      ADR_TRIG:   reg_rdata = trig_q;
      ADR_POL:    reg_rdata = pol_q;
      ADR_BOTH:   reg_rdata = both_q;
      ADR_MASK:   reg_rdata = mask_q;
      ADR_STATUS: reg_rdata = sts_q;
      default:    reg_rdata = '0;
    endcase
  end

  // R3: an edge-type pin never reports an event while its input is unchanged
  a_r3_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((evt & trig_q & ~(pin_in ^ $past(pin_in))) == '0));
endmodule

// File: tb/tb_pinbank_irq_detect.sv
module tb_pinbank_irq_detect;
  localparam int unsigned N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_in;
  logic         reg_wr;
  logic [2:0]   reg_addr;
  logic [N-1:0] reg_wdata;
  logic [N-1:0] reg_rdata;
  logic         irq;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pinbank_irq_detect #(.NPINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  logic [N-1:0] v;

  initial begin
    reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = '0; pin_in = '1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 type", v, 0);
    rd(3'd1, v); chk("R1 polarity", v, 0);
    rd(3'd2, v); chk("R1 both-edge", v, 0);
    rd(3'd5, v); chk("R1 mask", v, 8'hFF);
    rd(3'd6, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0);

    // R2 readback and strobe reads
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h0F);
    rd(3'd0, v); chk("R2 type", v, 8'hA5);
    rd(3'd1, v); chk("R2 polarity", v, 8'h3C);
    rd(3'd2, v); chk("R2 both-edge", v, 8'h0F);
    rd(3'd3, v); chk("R2 unmask reads zero", v, 0);
    rd(3'd4, v); chk("R2 mask-set reads zero", v, 0);

    // R6 mask strobes
    wr(3'd3, 8'h00); rd(3'd5, v); chk("R6 unmask zero no effect", v, 8'hFF);
    wr(3'd3, 8'h81); rd(3'd5, v); chk("R6 unmask", v, 8'h7E);
    wr(3'd4, 8'h00); rd(3'd5, v); chk("R6 mask-set zero no effect", v, 8'h7E);
    wr(3'd4, 8'h01); rd(3'd5, v); chk("R6 mask-set", v, 8'h7F);
    wr(3'd4, 8'hFF);

    // R7 sticky status, W1C, event wins
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'h00);
    @(negedge clk); pin_in = '0;
    @(negedge clk);
    wr(3'd6, 8'hFF);
    rd(3'd6, v); chk("R7 cleared", v, 0);
    pin_in[2] = 1'b1; @(negedge clk);
    rd(3'd6, v); chk("R3 rise sets", v, 8'h04);
    repeat (3) @(negedge clk);
    rd(3'd6, v); chk("R7 sticky", v, 8'h04);
    wr(3'd6, 8'h00); rd(3'd6, v); chk("R7 write zero no effect", v, 8'h04);
    wr(3'd6, 8'h04); rd(3'd6, v); chk("R7 W1C", v, 8'h00);
    @(negedge clk);
    pin_in[3] = 1'b1; reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h08;
    @(negedge clk); reg_wr = 1'b0;
    rd(3'd6, v); chk("R7 event beats clear", v, 8'h08);
    wr(3'd6, 8'h08); rd(3'd6, v); chk("R7 clear after", v, 8'h00);

    // R10 level pin cannot be cleared while active
    wr(3'd0, 8'hFE); wr(3'd1, 8'h01);
    @(negedge clk); pin_in[0] = 1'b1;
    wr(3'd6, 8'hFF); rd(3'd6, v); chk("R10 held while active", v, 8'h01);
    @(negedge clk); pin_in[0] = 1'b0;
    wr(3'd6, 8'hFF); rd(3'd6, v); chk("R10 clears when inactive", v, 8'h00);

    // Sweep: every pin x six modes x two starting levels (R3 R4 R5 R8 R9)
    for (int p = 0; p < N; p++) begin
      for (int m = 0; m < 6; m++) begin
        for (int s = 0; s < 2; s++) begin
          logic [N-1:0] bit_p, tv, pv, bv, base, exp_st;
          logic hit, nl;
          bit_p = N'(1) << p;
          tv = (m >= 4) ? ~bit_p : '1;
          pv = (m == 1 || m == 3 || m == 5) ? ~bit_p : '1;
          bv = (m >= 2) ? bit_p : '0;
          @(negedge clk); pin_in = (s != 0) ? '1 : '0;
          @(negedge clk);
          wr(3'd0, tv); wr(3'd1, pv); wr(3'd2, bv);
          wr(3'd6, 8'hFF);
          base = ((m == 4 && s == 1) || (m == 5 && s == 0)) ? bit_p : '0;
          rd(3'd6, v); chk("R5 baseline", v, base);
          nl = (s == 0);
          case (m)
            0: hit = (s == 0);
            1: hit = (s == 1);
            2, 3: hit = 1'b1;
            4: hit = nl;
            default: hit = !nl;
          endcase
          exp_st = base | (hit ? bit_p : '0);
          @(negedge clk); pin_in = pin_in ^ bit_p;
          @(negedge clk);
          rd(3'd6, v);
          if (m < 2) chk("R3 edge sweep", v, exp_st);
          else if (m < 4) chk("R4 both-edge sweep", v, exp_st);
          else chk("R5 level sweep", v, exp_st);
          chk("R8 masked irq low", irq, 0);
          wr(3'd3, bit_p);
          chk("R8 irq after unmask", irq, (exp_st != 0) ? 1 : 0);
          wr(3'd4, bit_p);
          chk("R9 irq low when masked", irq, 0);
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule